// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital controller for a successive-approximation converter. Software programs a configuration word and an averaging control word over a simple register bus. Writing a channel code to the channel-control register then starts one conversion. The block derives a conversion clock from the bus clock through a programmable divider. It requests 1, 4, 8, 16 or 32 raw samples from an external sample port, and each request falls at the end of a fixed time slot. The samples are summed and averaged with round-half-up. The average is masked to the selected resolution, stored, and flagged as complete. An interrupt line follows the flag when enabled.

A calibration command runs a timed busy phase. Its completion goes through the same completion flag and interrupt path as a conversion. If a conversion is requested while calibration is busy, the request is refused and a failure flag is set. Writing the idle channel code cancels a running conversion. Writing a valid code during a conversion restarts it on the new channel.

Top module: `adc_sequencer`

## Requirements
- R1: After reset the status, result and general-status registers read 0, the channel-control register reads 0x1F, and `irq` is low.
- R2: A write to channel control (offset 0x00) with code 0–15 in bits [4:0] starts a conversion. Its completion flag (status offset 0x08, bit 0) sets on the bus clock edge 6+28·N conversion-clock periods after the write edge, where N is the sample count. General-status (offset 0x1C) bit 0 reads 1 while the conversion runs.
- R3: One conversion-clock period is 2^(D+S) bus clocks. D is configuration (offset 0x14) bits [6:5]. S is 1 when configuration bits [1:0] equal 01 and 0 otherwise.
- R4: With averaging off (general control, offset 0x18, bit 5 = 0) one sample is taken. With averaging on, configuration bits [15:14] = 00/01/10/11 select 4/8/16/32 samples. `samp_strobe` pulses once per sample, each pulse at the end of a 28-period slot, with `samp_ch` equal to the requested channel.
- R5: The stored result is (sum + N/2) >> log2(N), where the N/2 term is 0 when N = 1.
- R6: Configuration bits [3:2] = 00/01/other mask the result to 0xFF/0x3FF/0xFFF.
- R7: `irq` is high exactly while the completion flag is set and the last accepted channel-control write had bit 7 set.
- R8: A bus read of the result register (offset 0x0C) clears the completion flag.
- R9: If a conversion completes while the flag is still set and configuration bit 16 is 0, the result register keeps its old value. If bit 16 is 1, the new result replaces it.
- R10: Writing code 0x1F stops a running conversion. No further samples are requested and the completion flag is not set.
- R11: Writing a valid code during a conversion restarts the conversion on the new channel, timed from the new write.
- R12: Writing general control with bit 7 set starts calibration. Bit 7 then reads 1 for 64 conversion-clock periods, after which it reads 0 and the completion flag sets.
- R13: A valid-code write during calibration starts no conversion and sets general-status bit 1. Starting calibration clears that bit. General-status bit 2 mirrors calibration busy.
- R14: A channel-control write with a code from 16 to 30 is ignored: the channel register, the running state and the flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| samp_strobe | output | 1 | Sample request; `samp_data` is taken on this edge |
| samp_ch | output | 4 | Channel being converted |
| samp_data | input | 12 | Raw sample from the analog front end |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong slot or divider count shows up as a completion flag one or more bus clocks away from the predicted edge. A wrong count of `samp_strobe` pulses is also visible within that same conversion. An accumulator or rounding fault changes the stored result, and alternating sample values push the round-half-up term across the resolution mask boundary to expose it. Faults in the flag or overwrite handling show on the first conversion that completes over an unread result. Faults in the calibration gate show in general status on the very next cycle after a refused request.

// File: rtl/adcs_pkg.sv
// Package: shared constants and helpers for the averaging conversion sequencer.
// Assumes a 6-bit byte-offset register bus and 12-bit raw samples.
package adcs_pkg;
    localparam int ADDR_W     = 6;
    localparam int SMP_W      = 12;
    localparam int ACC_W      = 17;
    localparam int CH_W       = 4;
    localparam int CODE_W     = 5;
    localparam int PRE_TICKS  = 6;
    localparam int SLOT_TICKS = 28;
    localparam int CAL_TICKS  = 64;
    localparam int MAX_LOG2   = 5;
    localparam int DIV_W      = 4;

    localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RES   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_GCTL  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_GSTAT = 6'h1C;

    localparam logic [CODE_W-1:0] CODE_IDLE = 5'h1F;

    // Result mask for a resolution selector.
    function automatic logic [SMP_W-1:0] res_mask(input logic [1:0] sel);
        case (sel)
            2'b00:   res_mask = 12'h0FF;
            2'b01:   res_mask = 12'h3FF;
            default: res_mask = 12'hFFF;
        endcase
    endfunction
endpackage

// File: rtl/adcs_tick_gen.sv
// Module: conversion-clock enable generator.
// Produces one tick every (div_m1+1) bus clocks while run is high; restart
// realigns the count so the first tick falls div_m1+1 clocks after it.
module adcs_tick_gen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] div_m1,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && !restart && (cnt_q == div_m1);

    // Divider count, cleared on restart or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt_q <= '0;
        else if (cnt_q == div_m1)      cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/adcs_conv.sv
// Module: conversion sequencer and averaging accumulator.
// Assumes one tick per conversion clock. A conversion spends PRE_TICKS ticks,
// then one SLOT_TICKS slot per sample; each slot ends with a sample strobe.
// Averaging count, resolution and channel are latched at start.
module adcs_conv
    import adcs_pkg::*;
#(
    parameter int P_SMP_W = SMP_W,
    parameter int P_ACC_W = ACC_W,
    parameter int P_CH_W  = CH_W,
    parameter int P_LOG2  = MAX_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic               tick,
    input  logic [2:0]         avg_log2,
    input  logic [1:0]         res_sel,
    input  logic [P_CH_W-1:0]  ch_in,
    input  logic [P_SMP_W-1:0] samp_data,
    output logic               busy,
    output logic               samp_strobe,
    output logic [P_CH_W-1:0]  samp_ch,
    output logic               done,
    output logic [P_SMP_W-1:0] result
);
    localparam int CYC_W = $clog2(SLOT_TICKS);
    localparam int IDX_W = P_LOG2;

    logic               busy_q, pre_q;
    logic [CYC_W-1:0]   cyc_q;
    logic [IDX_W-1:0]   idx_q;
    logic [P_ACC_W-1:0] acc_q;
    logic [2:0]         lg_q;
    logic [1:0]         res_q;
    logic [P_CH_W-1:0]  ch_q;

    logic [IDX_W:0]     n_cnt;
    logic               last_smp, slot_end;
    logic [P_ACC_W-1:0] sum_next, half, rounded, shifted;

    assign n_cnt    = (IDX_W+1)'(1) << lg_q;
    assign last_smp = ({1'b0, idx_q} == (n_cnt - 1'b1));
    assign slot_end = busy_q && tick && !pre_q && (cyc_q == CYC_W'(SLOT_TICKS-1));
    assign sum_next = acc_q + P_ACC_W'(samp_data);
    assign half     = (lg_q == 3'd0) ? '0 : (P_ACC_W'(1) << (lg_q - 3'd1));
    assign rounded  = sum_next + half;
    assign shifted  = rounded >> lg_q;

    assign busy        = busy_q;
    assign samp_strobe = slot_end;
    assign samp_ch     = ch_q;
    assign done        = slot_end && last_smp;
    assign result      = shifted[P_SMP_W-1:0] & P_SMP_W'(res_mask(res_q));

    logic unused_shift;
    assign unused_shift = ^shifted[P_ACC_W-1:P_SMP_W];

    // Sequencing: pre-phase, sample slots, accumulation, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; pre_q <= 1'b0; cyc_q <= '0; idx_q <= '0;
            acc_q  <= '0;   lg_q  <= '0;   res_q <= '0; ch_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1; pre_q <= 1'b1; cyc_q <= '0; idx_q <= '0;
            acc_q  <= '0;   lg_q  <= avg_log2; res_q <= res_sel; ch_q <= ch_in;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            if (pre_q) begin
                if (cyc_q == CYC_W'(PRE_TICKS-1)) begin
                    pre_q <= 1'b0;
                    cyc_q <= '0;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end else if (cyc_q == CYC_W'(SLOT_TICKS-1)) begin
                acc_q <= sum_next;
                cyc_q <= '0;
                if (last_smp) busy_q <= 1'b0;
                else          idx_q  <= idx_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    AST_DONE_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !abort) |=> !busy_q); // R2
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ({1'b0, idx_q} < n_cnt)); // R4
    AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start) |=> $stable(ch_q)); // R11
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start) |=> !busy_q); // R10
endmodule

// File: rtl/adcs_cal.sv
// Module: calibration timer.
// Holds busy for P_TICKS conversion-clock ticks after start, then pulses done.
// Assumes start is only given while not busy.
module adcs_cal #(
    parameter int P_TICKS = adcs_pkg::CAL_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(P_TICKS);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy = busy_q;
    assign done = busy_q && tick && (cnt_q == CW'(P_TICKS-1));

    // Tick counter for the calibration busy phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CAL_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q); // R12
endmodule

// File: rtl/adc_sequencer.sv
// Module: top of the averaging conversion sequencer.
// Holds the register file, decodes bus writes into start/abort/calibrate
// commands, latches the clock divide per run, and owns result, completion
// flag, calibration-failure flag and interrupt. Reads are combinational;
// bus_rd marks the cycle in which a read's side effect applies.
module adc_sequencer
    import adcs_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = 32,
    parameter int P_SMP_W  = SMP_W,
    parameter int P_CH_W   = CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    output logic                samp_strobe,
    output logic [P_CH_W-1:0]   samp_ch,
    input  logic [P_SMP_W-1:0]  samp_data,
    output logic                irq
);
    logic [CODE_W-1:0]  code_q;
    logic               ien_q, ow_q, avg_en_q, flag_q, fail_q;
    logic [1:0]         res_sel_q, src_q, div_sel_q, avg_sel_q;
    logic [P_SMP_W-1:0] result_q;
    logic [DIV_W-1:0]   div_m1_q;

    logic               wr_chan, wr_cfg, wr_gctl, rd_res;
    logic [CODE_W-1:0]  wcode;
    logic               code_ok, conv_req, start_conv, abort_conv, start_cal;
    logic [2:0]         div_pow, lg_next;
    logic [DIV_W-1:0]   div_m1_next;
    logic               tick, conv_busy, conv_done, cal_busy, cal_done;
    logic [P_SMP_W-1:0] conv_result;

    assign wr_chan    = bus_wr && (bus_addr == OFS_CHAN);
    assign wr_cfg     = bus_wr && (bus_addr == OFS_CFG);
    assign wr_gctl    = bus_wr && (bus_addr == OFS_GCTL);
    assign rd_res     = bus_rd && (bus_addr == OFS_RES);
    assign wcode      = bus_wdata[CODE_W-1:0];
    assign code_ok    = !wcode[CODE_W-1] || (wcode == CODE_IDLE);
    assign conv_req   = wr_chan && !wcode[CODE_W-1];
    assign start_conv = conv_req && !cal_busy;
    assign start_cal  = wr_gctl && bus_wdata[7] && !cal_busy;
    assign abort_conv = (wr_chan && (wcode == CODE_IDLE)) || start_cal;

    assign div_pow     = 3'(div_sel_q) + ((src_q == 2'b01) ? 3'd1 : 3'd0);
    assign div_m1_next = DIV_W'((1 << div_pow) - 1);
    assign lg_next     = avg_en_q ? (3'd2 + 3'(avg_sel_q)) : 3'd0;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[P_DATA_W-1:17], bus_wdata[13:8]};

    adcs_tick_gen #(.CNT_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(start_conv || start_cal),
        .run(conv_busy || cal_busy), .div_m1(div_m1_q), .tick(tick)
    );

    adcs_conv #(.P_SMP_W(P_SMP_W), .P_ACC_W(ACC_W), .P_CH_W(P_CH_W),
                .P_LOG2(MAX_LOG2)) u_conv (
        .clk(clk), .rst_n(rst_n), .start(start_conv), .abort(abort_conv),
        .tick(tick), .avg_log2(lg_next), .res_sel(res_sel_q),
        .ch_in(wcode[P_CH_W-1:0]), .samp_data(samp_data), .busy(conv_busy),
        .samp_strobe(samp_strobe), .samp_ch(samp_ch), .done(conv_done),
        .result(conv_result)
    );

    adcs_cal #(.P_TICKS(CAL_TICKS)) u_cal (
        .clk(clk), .rst_n(rst_n), .start(start_cal), .tick(tick),
        .busy(cal_busy), .done(cal_done)
    );

    // Configuration, channel code and per-run divide latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_IDLE; ien_q <= 1'b0; ow_q <= 1'b0; avg_en_q <= 1'b0;
            res_sel_q <= '0; src_q <= '0; div_sel_q <= '0; avg_sel_q <= '0;
            div_m1_q <= '0;
        end else begin
            if (wr_chan && code_ok && !(conv_req && cal_busy)) begin
                code_q <= wcode;
                ien_q  <= bus_wdata[7];
            end
            if (wr_cfg) begin
                ow_q      <= bus_wdata[16];
                avg_sel_q <= bus_wdata[15:14];
                div_sel_q <= bus_wdata[6:5];
                res_sel_q <= bus_wdata[3:2];
                src_q     <= bus_wdata[1:0];
            end
            if (wr_gctl) avg_en_q <= bus_wdata[5];
            if (start_conv || start_cal) div_m1_q <= div_m1_next;
        end
    end

    // Result store, completion flag and calibration failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0; flag_q <= 1'b0; fail_q <= 1'b0;
        end else begin
            if (conv_done) begin
                if (!flag_q || ow_q) result_q <= conv_result;
                flag_q <= 1'b1;
            end else if (cal_done) begin
                flag_q <= 1'b1;
            end else if (rd_res) begin
                flag_q <= 1'b0;
            end
            if (start_cal)                 fail_q <= 1'b0;
            else if (conv_req && cal_busy) fail_q <= 1'b1;
        end
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CHAN:  begin bus_rdata[7] = ien_q; bus_rdata[CODE_W-1:0] = code_q; end
            OFS_STAT:  bus_rdata[0] = flag_q;
            OFS_RES:   bus_rdata[P_SMP_W-1:0] = result_q;
            OFS_CFG:   begin
                bus_rdata[16] = ow_q;       bus_rdata[15:14] = avg_sel_q;
                bus_rdata[6:5] = div_sel_q; bus_rdata[3:2] = res_sel_q;
                bus_rdata[1:0] = src_q;
            end
            OFS_GCTL:  begin bus_rdata[7] = cal_busy; bus_rdata[5] = avg_en_q; end
            OFS_GSTAT: begin
                bus_rdata[2] = cal_busy; bus_rdata[1] = fail_q; bus_rdata[0] = conv_busy;
            end
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && ien_q;

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(conv_done || cal_done)); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && !conv_done && !cal_done) |=> !flag_q); // R8
    AST_KEEP_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && flag_q && !ow_q) |=> $stable(result_q)); // R9
    AST_FAIL_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> $past(cal_busy)); // R13
    AST_NO_CONV_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !conv_busy); // R13
endmodule

// File: tb/adc_sequencer_tb.sv
// Bench: directed corner cases plus seeded random configurations, checked
// against expected timing and averages computed here from the requirements.
module adc_sequencer_tb;
    localparam logic [5:0] A_CHAN = 6'h00, A_STAT = 6'h08, A_RES = 6'h0C,
                           A_CFG = 6'h14, A_GCTL = 6'h18, A_GSTAT = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = 6'h08;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        samp_strobe;
    logic [3:0]  samp_ch;
    logic [11:0] samp_data;
    logic        irq;

    int          n_chk = 0, n_fail = 0;
    logic        fixed_en = 1'b1;
    logic [11:0] fixed_val = 12'h123;
    logic [11:0] rnd_val = 12'h5A5;
    int          smp_seen = 0;
    longint      smp_sum = 0;
    logic [3:0]  exp_ch = '0;
    int          ch_err = 0;

    int cur_lg = 0, cur_div = 1, cur_res = 2;
    logic cur_ow = 1'b0, cur_avg_en = 1'b0;

    always #5 clk = ~clk;

    assign samp_data = fixed_en ? (fixed_val + (smp_seen[0] ? 12'd1 : 12'd0)) : rnd_val;

    adc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .samp_strobe(samp_strobe), .samp_ch(samp_ch), .samp_data(samp_data),
        .irq(irq)
    );

    // Sample port model: records what the design takes on each strobe.
    always @(posedge clk) begin
        if (samp_strobe) begin
            smp_sum  <= smp_sum + longint'(samp_data);
            smp_seen <= smp_seen + 1;
            if (samp_ch !== exp_ch) ch_err <= ch_err + 1;
            rnd_val  <= 12'($urandom);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_result();
        @(negedge clk);
        bus_addr = A_RES; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input int src, input int dv, input int res, input logic aen,
                           input int asel, input logic ow);
        bus_write(A_CFG, (32'(ow) << 16) | (32'(asel) << 14) | (32'(dv) << 5) |
                         (32'(res) << 2) | 32'(src));
        bus_write(A_GCTL, 32'(aen) << 5);
        cur_div = 1 << (dv + ((src == 1) ? 1 : 0));
        cur_lg  = aen ? 2 + asel : 0;
        cur_res = res; cur_ow = ow; cur_avg_en = aen;
    endtask

    function automatic logic [31:0] exp_avg(input longint sum, input int lg, input int res);
        longint r;
        logic [31:0] m;
        r = (sum + ((lg == 0) ? 0 : (longint'(1) << (lg - 1)))) >> lg;
        m = (res == 0) ? 32'hFF : (res == 1) ? 32'h3FF : 32'hFFF;
        return 32'(r) & m;
    endfunction

    // One conversion with cycle-exact completion and value checks.
    task automatic run_conv(input logic [3:0] ch, input logic ien, input logic clear_first);
        int n, cyc;
        logic [31:0] d, old_res, old_flag;
        if (clear_first) read_result();
        n = 1 << cur_lg;
        cyc = (6 + 28 * n) * cur_div;
        @(negedge clk);
        peek(A_RES, old_res);
        peek(A_STAT, old_flag);
        smp_sum <= 0; smp_seen <= 0; exp_ch = ch;
        bus_write(A_CHAN, (32'(ien) << 7) | 32'(ch));
        repeat (cyc - 1) @(posedge clk);
        @(negedge clk);
        peek(A_GSTAT, d); check("R2 busy before last edge", d & 1, 1);
        peek(A_STAT, d);  check("R2 flag before last edge", d, old_flag);
        @(posedge clk);
        @(negedge clk);
        peek(A_GSTAT, d); check("R2 busy after completion", d & 1, 0);
        peek(A_STAT, d);  check("R2 flag at completion", d, 1);
        check("R4 sample count", 32'(smp_seen), 32'(n));
        check("R4 sample channel", 32'(ch_err), 0);
        peek(A_RES, d);
        if (old_flag[0] && !cur_ow) check("R9 unread result kept", d, old_res);
        else check("R5 R6 averaged result", d, exp_avg(smp_sum, cur_lg, cur_res));
        check("R7 irq follows flag and enable", 32'(irq), 32'(ien));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240601));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        peek(A_STAT, d);  check("R1 status after reset", d, 0);
        peek(A_RES, d);   check("R1 result after reset", d, 0);
        peek(A_GSTAT, d); check("R1 general status after reset", d, 0);
        peek(A_CHAN, d);  check("R1 channel code after reset", d, 32'h1F);
        check("R1 irq after reset", 32'(irq), 0);

        // R2 R3: single sample, divide by 1, 12-bit.
        set_cfg(0, 0, 2, 1'b0, 0, 1'b0);
        fixed_en = 1'b1; fixed_val = 12'hABC;
        run_conv(4'd3, 1'b1, 1'b0);
        read_result();
        @(negedge clk);
        peek(A_STAT, d); check("R8 read clears flag", d, 0);
        check("R8 irq drops after read", 32'(irq), 0);

        // R5 R6: round-half-up carries across the 8-bit mask boundary.
        set_cfg(1, 0, 0, 1'b1, 0, 1'b0);
        fixed_val = 12'h7FF;
        run_conv(4'd7, 1'b0, 1'b1);
        peek(A_RES, d); check("R6 8-bit wrap after rounding", d, 32'h00);
        set_cfg(0, 1, 1, 1'b1, 0, 1'b0);
        fixed_val = 12'h200;
        run_conv(4'd1, 1'b1, 1'b1);
        peek(A_RES, d); check("R5 round half up", d, 32'h201);

        // R9: overwrite disabled keeps, enabled replaces.
        fixed_val = 12'h0F0;
        run_conv(4'd2, 1'b1, 1'b0);
        peek(A_RES, d); check("R9 kept with overwrite off", d, 32'h201);
        set_cfg(0, 1, 1, 1'b1, 0, 1'b1);
        run_conv(4'd2, 1'b1, 1'b0);
        peek(A_RES, d); check("R9 replaced with overwrite on", d, 32'h0F1);

        // R10: idle code aborts.
        read_result();
        smp_sum <= 0; smp_seen <= 0;
        bus_write(A_CHAN, 32'h85);
        repeat (20) @(posedge clk);
        bus_write(A_CHAN, 32'h1F);
        peek(A_GSTAT, d); check("R10 busy cleared by idle code", d & 1, 0);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        peek(A_STAT, d); check("R10 no completion after abort", d, 0);
        check("R10 no samples after abort", 32'(smp_seen), 0);

        // R11: restart mid-conversion on a new channel.
        bus_write(A_CHAN, 32'h02);
        repeat (10) @(posedge clk);
        run_conv(4'd9, 1'b0, 1'b0);
        peek(A_CHAN, d); check("R11 channel after restart", d, 32'h09);

        // R14: reserved codes are ignored.
        bus_write(A_CHAN, 32'h94);
        peek(A_CHAN, d);  check("R14 channel unchanged", d, 32'h09);
        peek(A_GSTAT, d); check("R14 no conversion started", d & 1, 0);

        // R12: calibration busy for 64 conversion clocks at divide by 2.
        set_cfg(0, 1, 2, 1'b0, 0, 1'b0);
        read_result();
        bus_write(A_GCTL, 32'h80);
        peek(A_GCTL, d); check("R12 calibration busy set", (d >> 7) & 1, 1);
        repeat (64 * 2 - 1) @(posedge clk);
        @(negedge clk);
        peek(A_GCTL, d); check("R12 busy before last edge", (d >> 7) & 1, 1);
        @(posedge clk);
        @(negedge clk);
        peek(A_GCTL, d); check("R12 busy cleared", (d >> 7) & 1, 0);
        peek(A_STAT, d); check("R12 completion flag set", d, 1);

        // R13: conversion request during calibration fails.
        read_result();
        smp_sum <= 0; smp_seen <= 0;
        bus_write(A_GCTL, 32'h80);
        bus_write(A_CHAN, 32'h01);
        peek(A_GSTAT, d); check("R13 failure flag and no conversion", d, 32'h6);
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R13 no samples during calibration", 32'(smp_seen), 0);
        bus_write(A_GCTL, 32'h80);
        peek(A_GSTAT, d); check("R13 new calibration clears failure", d & 2, 0);
        repeat (200) @(posedge clk);

        // R3 R4 R5 R6: seeded random configurations.
        fixed_en = 1'b0;
        for (int t = 0; t < 12; t++) begin
            int src, dv, res, asel;
            logic aen, ien;
            src = int'($urandom % 2); dv = int'($urandom % 4);
            res = int'($urandom % 3); asel = int'($urandom % 4);
            aen = 1'($urandom); ien = 1'($urandom);
            if (aen && asel >= 2) begin src = 0; dv = dv % 2; end
            set_cfg(src, dv, res, aen, asel, 1'b0);
            run_conv(4'($urandom), ien, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule